// File: doc/BRIEF.md
# Two-Plane Sprite and Crosshair Cursor Generator

This block produces two single-bit overlay planes, A and B, for every pixel of a raster, given the current pixel coordinates from the video timing logic. It can draw a 16x16 two-plane sprite whose upper-left corner sits at a programmed position, or a crosshair made of one horizontal and one vertical line through that position. The crosshair can be one or two pixels wide, and it can be limited to the inside of one of two rectangular regions. External region-detector outputs supply those regions.

Software drives the block through a 16-bit write-only port. A 2-bit select chooses the command register, the X position, the Y position or the sprite data port. The sprite rows are loaded through the data port while a load-mode bit is set, with an address counter that steps after each write. Most settings are written to shadow copies and only reach the display at the rising edge of vertical blank, so a frame never shows a half-written cursor. The two plane-force bits are the exception: they act at once. A test flip-flop records whether any plane or region output has asserted since a TEST bit was last cleared, so self-test software can check each output path on its own.

Top module: `cursor_gen`

## Requirements
- R1: While rst_n is low at a clock edge, all registers, the sprite rows and the load counter clear, so plane_a, plane_b and test_flag are 0 after reset.
- R2: wr_sel codes are 0 for the command, 1 for X position, 2 for Y position and 3 for sprite data. The command bits are: 0 test, 1 load, 2 crosshair, 3 width, 4 clip, 5 clip-select (1 = region1), 6 enable A, 7 enable B, 8 force A, 9 force B. Positions take wr_data[10:0].
- R3: While the load bit is 1, each sprite-data write stores a row at the counter and steps it. Writes 1 to 16 fill plane A rows 0 to 15, and writes 17 to 32 fill plane B rows 0 to 15. While the load bit is 1, sprite pixels are 0.
- R4: A command write that takes the load bit from 1 to 0 clears the counter, so the next load starts at plane A row 0.
- R5: Sprite-data writes while the load bit is 0 change neither the rows nor the counter.
- R6: In sprite mode (crosshair 0), the pixel (X+c, Y+r) for c, r in 0..15 shows bit 15-c of row r of each plane; bit 15 is the leftmost pixel. Pixels outside that window are 0.
- R7: A sprite that lies partly past the largest coordinate is clipped there and does not wrap to coordinate 0.
- R8: In crosshair mode, both planes are 1 where pix_x equals X or pix_y equals Y.
- R9: With the width bit set, the crosshair also covers pix_x = X+1 and pix_y = Y+1.
- R10: With the clip bit set, crosshair pixels appear only where the selected region input is 1.
- R11: Enables, crosshair, width, clip, clip-select and both positions take effect only on the clock where vblank rises, using the values written before that edge. A plane whose active enable is 0 outputs 0.
- R12: A force bit drives its plane to 1 at every pixel from the clock after the write, whatever the enable, mode, clip and sprite settings.
- R13: test_flag is cleared and held at 0 while the test bit is 1. While the test bit is 0, test_flag is set on the next clock by any of plane_a, plane_b, region1 or region2 being 1, and it then stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target select |
| wr_data | input | 16 | Write data |
| pix_x | input | 11 | Current raster X coordinate |
| pix_y | input | 11 | Current raster Y coordinate |
| vblank | input | 1 | Vertical blank, active high |
| region1 | input | 1 | Region detector 1 output |
| region2 | input | 1 | Region detector 2 output |
| plane_a | output | 1 | Cursor plane A pixel |
| plane_b | output | 1 | Cursor plane B pixel |
| test_flag | output | 1 | Test flip-flop state |

## Verification
The hardest case to reach is a load counter left part-way through the arrays. It only shows when a load is stopped early and a full reload follows. The stimulus writes three rows, drops and raises the load bit, and then reloads all 32 rows with a new pattern. It scans the sprite window, so any stale counter offset shifts every row by a visible amount. The shadow behaviour is reached the same way: writes are issued without a vblank rise, the raster is scanned to confirm nothing has changed, and then the edge is supplied. A sprite placed at coordinate 2040 is scanned across the wrap boundary.

// File: rtl/cursor_pkg.sv
// Package: shared command encoding and configuration type for the cursor block.
// Assumes a 16-bit write bus; bit positions here define the command layout.
package cursor_pkg;
    localparam int BUS_W = 16;

    localparam logic [1:0] SEL_CMD = 2'd0;
    localparam logic [1:0] SEL_XP  = 2'd1;
    localparam logic [1:0] SEL_YP  = 2'd2;
    localparam logic [1:0] SEL_SPR = 2'd3;

    localparam int B_TEST  = 0;
    localparam int B_LOAD  = 1;
    localparam int B_XHAIR = 2;
    localparam int B_WIDE  = 3;
    localparam int B_CLIP  = 4;
    localparam int B_CSEL  = 5;
    localparam int B_ENA   = 6;
    localparam int B_ENB   = 7;
    localparam int B_FRCA  = 8;
    localparam int B_FRCB  = 9;

    typedef struct packed {
        logic xhair;
        logic wide;
        logic clip;
        logic clip_sel;
        logic en_a;
        logic en_b;
    } disp_cfg_t;

    // Extract the shadowed display fields from a command word.
    function automatic disp_cfg_t cmd_to_cfg(input logic [BUS_W-1:0] d);
        disp_cfg_t c;
        c.xhair    = d[B_XHAIR];
        c.wide     = d[B_WIDE];
        c.clip     = d[B_CLIP];
        c.clip_sel = d[B_CSEL];
        c.en_a     = d[B_ENA];
        c.en_b     = d[B_ENB];
        return c;
    endfunction
endpackage

// File: rtl/cursor_regs.sv
// Register interface: decodes writes into shadow, active and immediate state,
// and runs the sprite load counter.
// Assumes COORD_W <= 16 and that the counter is as wide as the two-plane row space.
module cursor_regs
    import cursor_pkg::*;
#(
    parameter int COORD_W = 11,
    parameter int SPR_N   = 16,
    localparam int AW     = $clog2(2 * SPR_N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [BUS_W-1:0]   wr_data,
    input  logic               vblank,
    output disp_cfg_t          act_cfg,
    output logic [COORD_W-1:0] act_x,
    output logic [COORD_W-1:0] act_y,
    output logic               force_a,
    output logic               force_b,
    output logic               load_mode,
    output logic               test_mode,
    output logic               mem_we,
    output logic [AW-1:0]      mem_addr,
    output logic [SPR_N-1:0]   mem_wdata
);
    disp_cfg_t          shd_cfg;
    logic [COORD_W-1:0] shd_x, shd_y;
    logic               vb_q;
    logic [AW-1:0]      cnt_q;
    logic               cmd_wr, vb_rise, load_fall;

    assign cmd_wr    = wr_en && (wr_sel == SEL_CMD);
    assign vb_rise   = vblank && !vb_q;
    assign load_fall = cmd_wr && load_mode && !wr_data[B_LOAD];
    assign mem_we    = wr_en && (wr_sel == SEL_SPR) && load_mode;
    assign mem_addr  = cnt_q;
    assign mem_wdata = wr_data[SPR_N-1:0];

    // Shadow copies of the frame-buffered settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_cfg <= '0;
            shd_x   <= '0;
            shd_y   <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_CMD) shd_cfg <= cmd_to_cfg(wr_data);
            if (wr_sel == SEL_XP)  shd_x   <= wr_data[COORD_W-1:0];
            if (wr_sel == SEL_YP)  shd_y   <= wr_data[COORD_W-1:0];
        end
    end

    // Vertical blank edge detector.
    always_ff @(posedge clk) begin
        if (!rst_n) vb_q <= 1'b0;
        else        vb_q <= vblank;
    end

    // Copy the shadow settings to the active set on the blank rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_cfg <= '0;
            act_x   <= '0;
            act_y   <= '0;
        end else if (vb_rise) begin
            act_cfg <= shd_cfg;
            act_x   <= shd_x;
            act_y   <= shd_y;
        end
    end

    // Bits that act immediately: the forces, load mode and test.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            force_a   <= 1'b0;
            force_b   <= 1'b0;
            load_mode <= 1'b0;
            test_mode <= 1'b0;
        end else if (cmd_wr) begin
            force_a   <= wr_data[B_FRCA];
            force_b   <= wr_data[B_FRCB];
            load_mode <= wr_data[B_LOAD];
            test_mode <= wr_data[B_TEST];
        end
    end

    // Sprite load address counter.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (load_fall) cnt_q <= '0;
        else if (mem_we)    cnt_q <= cnt_q + 1'b1;
    end

    // R4: the counter is back at row 0 after load mode drops
    assert_cnt_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(load_mode) |-> (cnt_q == '0));

    // R5: the counter cannot move while load mode is off
    assert_cnt_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_mode |=> $stable(cnt_q));

    // R11: the active position and config only change on a blank rise
    assert_active_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(vblank && !vb_q) |=> ($stable(act_x) && $stable(act_y) && $stable(act_cfg)));
endmodule

// File: rtl/cursor_sprite_mem.sv
// Sprite storage: 2*SPR_N rows of SPR_N bits. Plane A sits in the lower half and
// plane B in the upper half. One write port; one row of each plane is read per pixel.
// Assumes SPR_N is a power of two.
module cursor_sprite_mem #(
    parameter int SPR_N = 16,
    localparam int RW   = $clog2(SPR_N),
    localparam int AW   = $clog2(2 * SPR_N),
    localparam int DEPTH = 2 * SPR_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [SPR_N-1:0] wdata,
    input  logic [RW-1:0]    rrow,
    output logic [SPR_N-1:0] row_a,
    output logic [SPR_N-1:0] row_b
);
    logic [SPR_N-1:0] mem [DEPTH];
    logic [SPR_N-1:0] rows [2];

    // Row storage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // One read port per plane, chosen by the top address bit.
    for (genvar p = 0; p < 2; p++) begin : g_plane_rd
        localparam logic PB = 1'(p);
        assign rows[p] = mem[{PB, rrow}];
    end

    assign row_a = rows[0];
    assign row_b = rows[1];
endmodule

// File: rtl/cursor_pixel.sv
// Per-pixel cursor logic: sprite window lookup, crosshair lines with width and
// clipping, then per-plane enable and force. Purely combinational.
// Assumes SPR_N is a power of two so that the reversed column is the complement.
module cursor_pixel
    import cursor_pkg::*;
#(
    parameter int COORD_W = 11,
    parameter int SPR_N   = 16,
    localparam int RW     = $clog2(SPR_N),
    localparam int EW     = COORD_W + 1
) (
    input  disp_cfg_t          cfg,
    input  logic [COORD_W-1:0] pos_x,
    input  logic [COORD_W-1:0] pos_y,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    input  logic               force_a,
    input  logic               force_b,
    input  logic               load_mode,
    input  logic               region1,
    input  logic               region2,
    input  logic [SPR_N-1:0]   row_a,
    input  logic [SPR_N-1:0]   row_b,
    output logic [RW-1:0]      rrow,
    output logic               plane_a,
    output logic               plane_b
);
    localparam logic [EW-1:0] SPAN = EW'(SPR_N);
    localparam logic [EW-1:0] ONE  = EW'(1);

    logic [EW-1:0] ex, ey, ax, ay, dx, dy;
    logic          in_win, spr_vis, on_v, on_h, clip_ok, xh_on;
    logic [RW-1:0] cidx;
    logic [1:0]    frc, en, sbit, plane;

    // Widened coordinates so that the window never wraps past the top value.
    always_comb begin
        ex = {1'b0, pix_x};
        ey = {1'b0, pix_y};
        ax = {1'b0, pos_x};
        ay = {1'b0, pos_y};
        dx = ex - ax;
        dy = ey - ay;
    end

    // Sprite window test and row/column selection.
    always_comb begin
        in_win  = (ex >= ax) && (dx < SPAN) && (ey >= ay) && (dy < SPAN);
        spr_vis = in_win && !load_mode;
        rrow    = dy[RW-1:0];
        cidx    = ~dx[RW-1:0];
    end

    // Crosshair lines, optional second pixel, optional region clip.
    always_comb begin
        on_v    = (ex == ax) || (cfg.wide && (ex == ax + ONE));
        on_h    = (ey == ay) || (cfg.wide && (ey == ay + ONE));
        clip_ok = !cfg.clip || (cfg.clip_sel ? region1 : region2);
        xh_on   = (on_v || on_h) && clip_ok;
    end

    assign frc  = {force_b, force_a};
    assign en   = {cfg.en_b, cfg.en_a};
    assign sbit = {row_b[cidx], row_a[cidx]};

    // Per-plane output: force wins, otherwise enable-gated cursor data.
    for (genvar p = 0; p < 2; p++) begin : g_plane_out
        assign plane[p] = frc[p] | (en[p] & (cfg.xhair ? xh_on : (spr_vis & sbit[p])));
    end

    assign plane_a = plane[0];
    assign plane_b = plane[1];
endmodule

// File: rtl/cursor_gen.sv
// Top of the two-plane cursor generator: register interface, sprite rows,
// pixel logic and the self-test flip-flop.
// Assumes pix_x/pix_y and region inputs are synchronous to clk.
module cursor_gen
    import cursor_pkg::*;
#(
    parameter int COORD_W = 11,
    parameter int SPR_N   = 16,
    localparam int RW     = $clog2(SPR_N),
    localparam int AW     = $clog2(2 * SPR_N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [BUS_W-1:0]   wr_data,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    input  logic               vblank,
    input  logic               region1,
    input  logic               region2,
    output logic               plane_a,
    output logic               plane_b,
    output logic               test_flag
);
    disp_cfg_t          act_cfg;
    logic [COORD_W-1:0] act_x, act_y;
    logic               force_a, force_b, load_mode, test_mode, mem_we;
    logic [AW-1:0]      mem_addr;
    logic [SPR_N-1:0]   mem_wdata, row_a, row_b;
    logic [RW-1:0]      rrow;

    cursor_regs #(.COORD_W(COORD_W), .SPR_N(SPR_N)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .vblank(vblank), .act_cfg(act_cfg), .act_x(act_x), .act_y(act_y),
        .force_a(force_a), .force_b(force_b), .load_mode(load_mode),
        .test_mode(test_mode), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    cursor_sprite_mem #(.SPR_N(SPR_N)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
        .rrow(rrow), .row_a(row_a), .row_b(row_b)
    );

    cursor_pixel #(.COORD_W(COORD_W), .SPR_N(SPR_N)) u_pix (
        .cfg(act_cfg), .pos_x(act_x), .pos_y(act_y), .pix_x(pix_x), .pix_y(pix_y),
        .force_a(force_a), .force_b(force_b), .load_mode(load_mode),
        .region1(region1), .region2(region2), .row_a(row_a), .row_b(row_b),
        .rrow(rrow), .plane_a(plane_a), .plane_b(plane_b)
    );

    // Self-test flip-flop: cleared by TEST, set by any plane or region output.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         test_flag <= 1'b0;
        else if (test_mode)                                 test_flag <= 1'b0;
        else if (plane_a || plane_b || region1 || region2)  test_flag <= 1'b1;
    end

    // R13: the flag is low on the clock after TEST is seen high
    assert_test_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |=> !test_flag);

    // R13: an active output with TEST low sets the flag
    assert_test_set_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_mode && (plane_a || plane_b || region1 || region2)) |=> test_flag);
endmodule

// File: tb/cursor_gen_tb.sv
`timescale 1ns/1ps
module cursor_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [10:0] pix_x = 11'd0, pix_y = 11'd0;
    logic        vblank = 1'b0, region1 = 1'b0, region2 = 1'b0;
    logic        plane_a, plane_b, test_flag;

    int checks = 0, fails = 0;
    bit done = 0, chk_on = 0;
    string cur_req = "R1";

    // Behavioural model state
    int m_fa, m_fb, m_load, m_test;
    int s_xh, s_wid, s_clip, s_sel, s_ena, s_enb, s_x, s_y;
    int a_xh, a_wid, a_clip, a_sel, a_ena, a_enb, a_x, a_y;
    int mem [32];
    int cnt, tflag, vbp;
    int exp_a, exp_b;

    always #2.5 clk = ~clk;

    cursor_gen u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .pix_x(pix_x), .pix_y(pix_y), .vblank(vblank), .region1(region1),
        .region2(region2), .plane_a(plane_a), .plane_b(plane_b), .test_flag(test_flag)
    );

    function automatic int exp_plane(int p);
        int x = int'(pix_x), y = int'(pix_y);
        int f  = p ? m_fb : m_fa;
        int en = p ? a_enb : a_ena;
        if (f != 0) return 1;
        if (en == 0) return 0;
        if (a_xh != 0) begin
            int on = (x == a_x) || (y == a_y) ||
                     (a_wid != 0 && (x == a_x + 1 || y == a_y + 1));
            int rg = a_sel ? int'(region1) : int'(region2);
            return (on != 0 && (a_clip == 0 || rg != 0)) ? 1 : 0;
        end
        if (m_load != 0) return 0;
        if (x >= a_x && x < a_x + 16 && y >= a_y && y < a_y + 16)
            return (mem[p * 16 + (y - a_y)] >> (15 - (x - a_x))) & 1;
        return 0;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual %0d expected %0d (x=%0d y=%0d)",
                     req, what, act, exp, pix_x, pix_y);
        end
    endtask

    task automatic model_reset();
        m_fa = 0; m_fb = 0; m_load = 0; m_test = 0;
        s_xh = 0; s_wid = 0; s_clip = 0; s_sel = 0; s_ena = 0; s_enb = 0; s_x = 0; s_y = 0;
        a_xh = 0; a_wid = 0; a_clip = 0; a_sel = 0; a_ena = 0; a_enb = 0; a_x = 0; a_y = 0;
        for (int i = 0; i < 32; i++) mem[i] = 0;
        cnt = 0; tflag = 0; vbp = 0;
    endtask

    task automatic model_update();
        int d;
        if (!rst_n) begin model_reset(); return; end
        d = int'(wr_data);
        if (m_test != 0) tflag = 0;
        else if (exp_a != 0 || exp_b != 0 || region1 || region2) tflag = 1;
        if (vblank && vbp == 0) begin
            a_xh = s_xh; a_wid = s_wid; a_clip = s_clip; a_sel = s_sel;
            a_ena = s_ena; a_enb = s_enb; a_x = s_x; a_y = s_y;
        end
        if (wr_en) begin
            case (wr_sel)
                2'd0: begin
                    if (m_load != 0 && ((d >> 1) & 1) == 0) cnt = 0;
                    m_test = d & 1;         m_load = (d >> 1) & 1;
                    s_xh   = (d >> 2) & 1;  s_wid  = (d >> 3) & 1;
                    s_clip = (d >> 4) & 1;  s_sel  = (d >> 5) & 1;
                    s_ena  = (d >> 6) & 1;  s_enb  = (d >> 7) & 1;
                    m_fa   = (d >> 8) & 1;  m_fb   = (d >> 9) & 1;
                end
                2'd1: s_x = d & 2047;
                2'd2: s_y = d & 2047;
                default: if (m_load != 0) begin mem[cnt] = d; cnt = (cnt + 1) % 32; end
            endcase
        end
        vbp = vblank ? 1 : 0;
    endtask

    // One cycle: compare just before the edge, then advance model and DUT.
    task automatic tick();
        #1;
        exp_a = exp_plane(0);
        exp_b = exp_plane(1);
        if (chk_on) begin
            check(cur_req, "plane_a", int'(plane_a), exp_a);
            check(cur_req, "plane_b", int'(plane_b), exp_b);
            check(cur_req, "test_flag", int'(test_flag), tflag);
        end
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic wr(logic [1:0] sel, int data);
        wr_en = 1'b1; wr_sel = sel; wr_data = 16'(data);
        tick();
        wr_en = 1'b0;
    endtask

    task automatic vb_pulse();
        vblank = 1'b1; tick();
        vblank = 1'b0; tick();
    endtask

    task automatic scan(int x0, int x1, int y0, int y1, int rmode);
        for (int y = y0; y <= y1; y++) begin
            for (int x = x0; x <= x1; x++) begin
                pix_x = 11'(x); pix_y = 11'(y);
                region1 = (rmode != 0) ? 1'(((x + y) >> 1) & 1) : 1'b0;
                region2 = (rmode != 0) ? 1'(x & 1) : 1'b0;
                tick();
            end
        end
        region1 = 1'b0; region2 = 1'b0;
    endtask

    task automatic load_all(int seed);
        wr(2'd0, 16'h0002);                 // R3: load mode on
        for (int i = 0; i < 32; i++) wr(2'd3, (i * 16'h1357 + seed) & 16'hFFFF);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual 0 expected 1");
        finish_run();
    end

    initial begin
        model_reset();
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;
        // R1: reset state
        #1;
        check("R1", "plane_a", int'(plane_a), 0);
        check("R1", "plane_b", int'(plane_b), 0);
        check("R1", "test_flag", int'(test_flag), 0);
        @(negedge clk);
        chk_on = 1;

        // R3/R2: load both planes, then show the sprite
        cur_req = "R3";
        load_all(16'h00A5);
        wr(2'd0, 16'h00C0);                 // load off, enables on, sprite mode
        wr(2'd1, 100); wr(2'd2, 50);
        vb_pulse();
        cur_req = "R6";
        scan(98, 117, 48, 67, 0);

        // R3: sprite pixels held at 0 while load mode is set
        cur_req = "R3";
        wr(2'd0, 16'h00C2);
        scan(99, 116, 49, 52, 0);

        // R4: partial load, drop and restart, full reload
        cur_req = "R4";
        for (int i = 0; i < 3; i++) wr(2'd3, 16'hDEAD);
        wr(2'd0, 16'h00C0);
        load_all(16'h3C1F);
        wr(2'd0, 16'h00C0);
        scan(99, 116, 49, 66, 0);

        // R5: data writes with load off are ignored
        cur_req = "R5";
        for (int i = 0; i < 5; i++) wr(2'd3, 16'hFFFF);
        scan(99, 116, 49, 66, 0);

        // R7: sprite at the edge of the coordinate space, no wrap
        cur_req = "R7";
        wr(2'd1, 2040); wr(2'd2, 2040);
        vb_pulse();
        scan(2036, 2047, 2038, 2047, 0);
        scan(0, 5, 0, 3, 0);
        scan(2036, 2047, 0, 3, 0);

        // R11: writes without a blank rise leave the display unchanged
        cur_req = "R11";
        wr(2'd1, 300); wr(2'd2, 200);
        wr(2'd0, 16'h00C4);                 // crosshair, not yet active
        scan(2040, 2047, 2044, 2047, 0);
        scan(296, 304, 198, 202, 0);
        vblank = 1'b1; tick(); tick(); vblank = 1'b0; tick();

        // R8: one-pixel crosshair
        cur_req = "R8";
        scan(296, 304, 196, 204, 0);
        scan(10, 12, 200, 200, 0);

        // R9: two-pixel crosshair
        cur_req = "R9";
        wr(2'd0, 16'h00CC);
        vb_pulse();
        scan(296, 304, 196, 204, 0);

        // R10: clip to region 1, then to region 2
        cur_req = "R10";
        wr(2'd0, 16'h00FC);
        vb_pulse();
        scan(296, 304, 196, 204, 1);
        wr(2'd0, 16'h00DC);
        vb_pulse();
        scan(296, 304, 196, 204, 1);

        // R11: plane B disabled outputs 0
        cur_req = "R11";
        wr(2'd0, 16'h0044);
        vb_pulse();
        scan(298, 302, 198, 202, 0);

        // R12: force bits act at once over a disabled plane and clipping
        cur_req = "R12";
        wr(2'd0, 16'h0214);
        scan(0, 3, 0, 1, 0);
        wr(2'd0, 16'h0314);
        scan(500, 503, 600, 601, 0);
        wr(2'd0, 16'h0014);

        // R13: test flag cleared and held, then set by a region pulse
        cur_req = "R13";
        wr(2'd0, 16'h0001);
        pix_x = 11'd1000; pix_y = 11'd1000;
        tick(); tick();
        region1 = 1'b1; tick(); tick(); region1 = 1'b0;
        wr(2'd0, 16'h0000);
        tick();
        region2 = 1'b1; tick(); region2 = 1'b0;
        repeat (3) tick();
        check("R13", "test_flag held", int'(test_flag), 1);

        finish_run();
    end
endmodule